// File: doc/BRIEF.md
# Two-Level ALU with Local Operation Decode

This block is the arithmetic/logic stage of a single-cycle integer datapath. It has two parts. The first is a local decoder. It takes a 2-bit operation class from the main instruction controller and, for register-type instructions, the 6-bit function field. From these it picks one of six ALU operations and shows the choice as a 4-bit select. The second part is a 32-bit ALU. It applies the chosen operation to two operands and returns the result and a zero flag.

Memory instructions use class 00 to compute addresses. Branch-equal uses class 01 to compare two registers through subtraction. Register-type instructions use class 10, where the function field chooses the operation. OR-immediate uses class 11. The whole block is combinational, so every output follows its inputs within the same cycle.

Top module: `alu_local_ctl`

## Requirements
- R1: With op_class 00 the select is 4'b0010 and the result is opnd_a + opnd_b, whatever funct holds.
- R2: With op_class 01 the select is 4'b0110 and the result is opnd_a - opnd_b, whatever funct holds.
- R3: With op_class 10 the function field decodes as follows: 6'd32 gives add (select 0010), 6'd34 gives subtract (0110), 6'd36 gives bitwise AND (0000), and 6'd37 gives bitwise OR (0001).
- R4: With op_class 11 the select is 4'b0001 and the result is opnd_a | opnd_b, whatever funct holds.
- R5: With op_class 10, any funct value other than 32, 34, 36, 37, 39 or 42 selects add (0010) and drives bad_funct to 1. In every other case bad_funct is 0.
- R6: With op_class 10 and funct 6'd42, the select is 4'b0111. The result is 32'd1 when opnd_a is less than opnd_b as signed two's-complement numbers, and 32'd0 otherwise.
- R7: With op_class 10 and funct 6'd39, the select is 4'b1100 and the result is ~(opnd_a | opnd_b).
- R8: Add and subtract wrap modulo 2^32 and give no overflow indication.
- R9: zero is 1 exactly when all 32 bits of the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of a register-type instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_sel | output | 4 | Decoded ALU operation select |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |
| bad_funct | output | 1 | Unrecognised function code under class 10 |

## Verification
Every output is combinational, so each result is due in the same cycle as the stimulus that produces it, with no register delay. The bench changes the inputs just after a rising clock edge. It then compares alu_sel, result, zero and bad_funct on the following falling edge, by which time the outputs have settled. The inputs are held still until the next rising edge, so each sample shows one stimulus and nothing else.

// File: rtl/alu_local_ctl.sv
module alu_local_ctl #(
  parameter int W = 32
) (
  input  logic [1:0]   op_class,
  input  logic [5:0]   funct,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [3:0]   alu_sel,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         bad_funct
);
  localparam logic [3:0] SEL_AND = 4'b0000;
  localparam logic [3:0] SEL_OR  = 4'b0001;
  localparam logic [3:0] SEL_ADD = 4'b0010;
  localparam logic [3:0] SEL_SUB = 4'b0110;
  localparam logic [3:0] SEL_SLT = 4'b0111;
  localparam logic [3:0] SEL_NOR = 4'b1100;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  logic [3:0] fn_sel;
  logic       fn_bad;

  always_comb begin
    fn_bad = 1'b0;
    case (funct)
      FN_ADD:  fn_sel = SEL_ADD;
      FN_SUB:  fn_sel = SEL_SUB;
      FN_AND:  fn_sel = SEL_AND;
      FN_OR:   fn_sel = SEL_OR;
      FN_NOR:  fn_sel = SEL_NOR;
      FN_SLT:  fn_sel = SEL_SLT;
      default: begin
        fn_sel = SEL_ADD;
        fn_bad = 1'b1;
      end
    endcase
  end

  always_comb begin
    case (op_class)
      2'b00:   alu_sel = SEL_ADD;
      2'b01:   alu_sel = SEL_SUB;
      2'b10:   alu_sel = fn_sel;
      default: alu_sel = SEL_OR;
    endcase
  end

  assign bad_funct = (op_class == 2'b10) && fn_bad;

  logic [W-1:0] sum, diff;
  logic         a_lt_b;

  assign sum    = opnd_a + opnd_b;
  assign diff   = opnd_a - opnd_b;
  assign a_lt_b = $signed(opnd_a) < $signed(opnd_b);

  always_comb begin
    case (alu_sel)
      SEL_AND: result = opnd_a & opnd_b;
      SEL_OR:  result = opnd_a | opnd_b;
      SEL_SUB: result = diff;
      SEL_SLT: result = {{(W-1){1'b0}}, a_lt_b};
      SEL_NOR: result = ~(opnd_a | opnd_b);
      default: result = sum;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/alu_local_ctl_chk.sv
module alu_local_ctl_chk #(
  parameter int W = 32
) (
  input logic [1:0]   op_class,
  input logic [5:0]   funct,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   alu_sel,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         bad_funct
);
  always_comb begin
    if (op_class == 2'b00)
      assert_addr_add_R1: assert (result == W'(opnd_a + opnd_b));
    if (op_class == 2'b01)
      assert_branch_zero_R2: assert (zero == (opnd_a == opnd_b));
    if (op_class == 2'b11)
      assert_ori_sel_R4: assert (alu_sel == 4'b0001);
    if (op_class != 2'b10)
      assert_no_bad_R5: assert (!bad_funct);
    if (alu_sel == 4'b0111)
      assert_slt_bit_R6: assert (result[W-1:1] == '0);
    if (bad_funct)
      assert_bad_add_R5: assert (alu_sel == 4'b0010);
  end
endmodule

bind alu_local_ctl alu_local_ctl_chk #(.W(W)) chk (
  .op_class(op_class), .funct(funct), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .alu_sel(alu_sel), .result(result), .zero(zero), .bad_funct(bad_funct)
);

// File: tb/alu_local_ctl_test.sv
module alu_local_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] opnd_a, opnd_b;
  logic [3:0]  alu_sel;
  logic [31:0] result;
  logic        zero, bad_funct;

  int total = 0;
  int bad = 0;

  alu_local_ctl uut (
    .op_class(op_class), .funct(funct), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_sel(alu_sel), .result(result), .zero(zero), .bad_funct(bad_funct)
  );

  function automatic logic exp_bad(input logic [1:0] c, input logic [5:0] f);
    if (c != 2'b10) return 1'b0;
    return !(f == 6'd32 || f == 6'd34 || f == 6'd36 ||
             f == 6'd37 || f == 6'd39 || f == 6'd42);
  endfunction

  function automatic logic [3:0] exp_sel(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return 4'b0010;
    if (c == 2'b01) return 4'b0110;
    if (c == 2'b11) return 4'b0001;
    case (f)
      6'd34:   return 4'b0110;
      6'd36:   return 4'b0000;
      6'd37:   return 4'b0001;
      6'd39:   return 4'b1100;
      6'd42:   return 4'b0111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [31:0] exp_res(input logic [3:0] s, input logic [31:0] a,
                                          input logic [31:0] b);
    case (s)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0110: return a - b;
      4'b0111: return (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
      4'b1100: return ~(a | b);
      default: return a + b;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    if (c == 2'b11) return "R4";
    if (exp_bad(c, f)) return "R5";
    if (f == 6'd42) return "R6";
    if (f == 6'd39) return "R7";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (class=%b funct=%0d a=%h b=%h)",
               req, what, act, exp, op_class, funct, opnd_a, opnd_b);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [3:0]  s;
    logic [31:0] r;
    @(posedge clk);
    op_class = c; funct = f; opnd_a = a; opnd_b = b;
    s = exp_sel(c, f);
    r = exp_res(s, a, b);
    @(negedge clk);
    check(tag, {28'd0, alu_sel}, {28'd0, s}, "alu_sel");
    check(tag, result, r, "result");
    check("R9", {31'd0, zero}, {31'd0, (r == 32'd0)}, "zero");
    check("R5", {31'd0, bad_funct}, {31'd0, exp_bad(c, f)}, "bad_funct");
  endtask

  initial begin
    #150000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [5:0] codes [6];
    codes = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd39, 6'd42};
    seed = 17;
    void'($urandom(seed));
    op_class = 2'b00; funct = 6'd0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", result, 32'd0, "initial result");
    check("R9", {31'd0, zero}, 32'd1, "initial zero");

    apply(2'b00, 6'd34, 32'd100, 32'd28, "R1");
    apply(2'b00, 6'd42, 32'hFFFF_FFFC, 32'd8, "R1");
    apply(2'b01, 6'd32, 32'd55, 32'd55, "R2");
    apply(2'b01, 6'd36, 32'd10, 32'd3, "R2");
    apply(2'b10, 6'd32, 32'd7, 32'd9, "R3");
    apply(2'b10, 6'd34, 32'd7, 32'd9, "R3");
    apply(2'b10, 6'd36, 32'hF0F0_00FF, 32'h0FF0_0F0F, "R3");
    apply(2'b10, 6'd37, 32'hF000_0000, 32'h0000_000F, "R3");
    apply(2'b11, 6'd34, 32'h1234_0000, 32'h0000_5678, "R4");
    apply(2'b10, 6'd0,  32'd4, 32'd5, "R5");
    apply(2'b10, 6'd63, 32'd1, 32'd2, "R5");
    apply(2'b10, 6'd33, 32'hFFFF_FFFF, 32'd1, "R5");
    apply(2'b10, 6'd42, 32'hFFFF_FFFF, 32'd1, "R6");
    apply(2'b10, 6'd42, 32'd1, 32'hFFFF_FFFF, "R6");
    apply(2'b10, 6'd42, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
    apply(2'b10, 6'd42, 32'd5, 32'd5, "R6");
    apply(2'b10, 6'd39, 32'd0, 32'd0, "R7");
    apply(2'b10, 6'd39, 32'hFFFF_0000, 32'h0000_FFFF, "R7");
    apply(2'b00, 6'd0, 32'h7FFF_FFFF, 32'd1, "R8");
    apply(2'b00, 6'd0, 32'hFFFF_FFFF, 32'd1, "R8");
    apply(2'b01, 6'd0, 32'd0, 32'd1, "R8");
    apply(2'b10, 6'd34, 32'h8000_0000, 32'd1, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  c;
      logic [5:0]  f;
      logic [31:0] a, b;
      c = 2'($urandom);
      f = ($urandom % 4 != 0) ? codes[$urandom % 6] : 6'($urandom);
      a = $urandom;
      b = ($urandom % 8 == 0) ? a : $urandom;
      if ($urandom % 16 == 0) a = 32'h8000_0000;
      apply(c, f, a, b, req_of(c, f));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule